// File: doc/BRIEF.md
# Interleaved Vector Element Memory

This block is a word memory split into a parameterised number of independent banks. It serves streaming vector transfers. A client issues one command holding a start address, an element count and a read or write flag. The block then walks the elements in index order at unit stride and touches one element per cycle.

Consecutive addresses fall into consecutive banks. A bank that has just been accessed needs a few cycles to recover. While it recovers, the following elements go to other banks. When enough banks exist, the recovery time is fully hidden and a long vector streams at one element per clock.

If the bank holding the next element is still recovering, the block holds that element and stalls. No later element may overtake it. For writes, the block takes the client's data word in the cycle the element issues. For reads, each word comes back one cycle after its issue, tagged with its element index.

Top module: `vec_interleave_mem`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `busy`, `issue`, `stall`, `done` and `rd_valid` are all 0.
- R2: Element i of a command uses address a = (base + i) mod (BANKS*ROWS). It goes to bank a mod BANKS (the low address bits, shown on `issue_bank`) and to row a div BANKS.
- R3: Once a bank is accessed, it is not accessed in the next RECOVERY cycles. A command that targets only one bank issues one element and then stalls RECOVERY-1 cycles when it starts in the cycle after the previous command's `done`.
- R4: While a transfer is active and the bank of the next element is recovering, `stall` is 1, `issue` is 0 and `issue_idx` holds its value.
- R5: Elements issue strictly in index order. `issue_idx` is 0 on the first issue and rises by exactly 1 on each following issue, up to length-1.
- R6: A read element issued in cycle t gives `rd_valid`=1 in cycle t+1, with `rd_idx` equal to its index and `rd_data` equal to the last word written to its address.
- R7: A write element stores the `wr_data` present in its issue cycle at its address. A write never raises `rd_valid`.
- R8: With BANKS >= RECOVERY+1 and all banks recovered, a unit-stride 64-element transfer issues on 64 consecutive cycles with no stall.
- R9: A command with length 0 is dropped. It causes no issue, no `done`, and `busy` stays 0.
- R10: `done` is a one-cycle pulse in the cycle after the last element issues, and `cmd_ready` is 1 again in that same cycle.
- R11: A command offered while `busy` is 1 is ignored. Its addresses are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_write | input | 1 | 1 = write transfer, 0 = read transfer |
| cmd_base | input | ADDR_W | Address of element 0 |
| cmd_len | input | LEN_W | Element count, 0 to MAX_LEN |
| cmd_ready | output | 1 | Block is idle and takes a command on this edge |
| wr_data | input | DATA_W | Write word for the element now shown on `issue_idx` |
| busy | output | 1 | A transfer is in progress |
| stall | output | 1 | Next element waits for a recovering bank |
| issue | output | 1 | Element `issue_idx` accesses its bank this cycle |
| issue_idx | output | IDX_W | Index of the next or current element |
| issue_bank | output | BANK_W | Bank of that element |
| done | output | 1 | Pulse after the last element of a transfer |
| rd_valid | output | 1 | Read word present |
| rd_idx | output | IDX_W | Element index of the read word |
| rd_data | output | DATA_W | Read word |

## Verification
A command applied before an edge makes `busy` rise in the next cycle. `issue`, `stall`, `issue_idx` and `issue_bank` are combinational in each active cycle. A read word shows up one cycle after its issue, and `done` and `cmd_ready` follow one cycle after the last issue. The bench drives inputs and samples outputs at the falling edge. In each active cycle it checks either an issue (index, bank, write capture) or a stall. It checks a pending read word one sample later. After the loop it checks `done` at the first sample following the last issue. The recovery window is measured as a stall count between same-bank commands that start back to back.

// File: rtl/vim_pkg.sv
package vim_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

endpackage

// File: rtl/vim_bank.sv
module vim_bank #(
  parameter int ROWS     = 16,
  parameter int DATA_W   = 16,
  parameter int RECOVERY = 3,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int CNT_W   = (RECOVERY > 0) ? $clog2(RECOVERY + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_wr,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [ROWS];
  logic [CNT_W-1:0]  cool_cnt;

  // recovery down-counter: reloaded on every access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cool_cnt <= '0;
    end else if (acc) begin
      cool_cnt <= CNT_W'(RECOVERY);
    end else if (cool_cnt != '0) begin
      cool_cnt <= cool_cnt - CNT_W'(1);
    end
  end

  assign ready = (cool_cnt == '0);

  always_ff @(posedge clk) begin
    if (acc && acc_wr) begin
      store[acc_row] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && !acc_wr) begin
      rdata <= store[acc_row];
    end
  end

  // R3: an access always leaves the bank unavailable on the next cycle
  p_bank_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (RECOVERY != 0)) |=> !ready);

  // R3: the bank is never accessed on two adjacent cycles when recovery exists
  p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (RECOVERY != 0)) |=> !acc);

endmodule

// File: rtl/vim_seq.sv
module vim_seq
  import vim_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ADDR_W  = 6,
  parameter int IDX_W   = 6,
  localparam int LEN_W  = IDX_W + 1,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [BANKS-1:0]  bank_ready,
  output logic              cmd_ready,
  output logic              busy,
  output logic              issue,
  output logic              issue_wr,
  output logic              stall,
  output logic [IDX_W-1:0]  issue_idx,
  output logic [BANK_W-1:0] issue_bank,
  output logic [ROW_W-1:0]  issue_row,
  output logic              done
);

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BANK_W];
  endfunction

  function automatic logic [ADDR_W-1:0] elem_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0]  idx);
    return base + ADDR_W'(idx);
  endfunction

  logic              active;
  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_free;
  logic              last_elem;
  logic              accept;

  assign cur_addr   = elem_addr(base_q, idx_q);
  assign issue_bank = bank_of(cur_addr);
  assign issue_row  = row_of(cur_addr);
  assign cur_free   = bank_ready[issue_bank];
  assign issue      = active && cur_free;
  assign stall      = active && !cur_free;
  assign issue_wr   = (op_q == OP_WRITE);
  assign issue_idx  = idx_q;
  assign busy       = active;
  assign cmd_ready  = !active;
  assign last_elem  = ({1'b0, idx_q} == (len_q - LEN_W'(1)));
  assign accept     = !active && cmd_valid && (cmd_len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      op_q   <= OP_READ;
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        active <= 1'b1;
        op_q   <= cmd_write ? OP_WRITE : OP_READ;
        base_q <= cmd_base;
        len_q  <= cmd_len;
        idx_q  <= '0;
      end else if (issue) begin
        if (last_elem) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  // R4: a stalled element keeps its index on the next cycle
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (issue_idx == $past(issue_idx)));

  // R5: after a non-final issue the next index is one higher
  p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && busy && !last_elem) |=> (issue_idx == $past(issue_idx) + IDX_W'(1)));

  // R10: done only follows an issue
  p_done_after_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(issue) && cmd_ready));

endmodule

// File: rtl/vim_return.sv
module vim_return #(
  parameter int BANKS   = 4,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 6,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_wr,
  input  logic [IDX_W-1:0]  issue_idx,
  input  logic [BANK_W-1:0] issue_bank,
  input  logic [DATA_W-1:0] bank_rdata [BANKS],
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [BANK_W-1:0] src_bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_idx     <= '0;
      src_bank_q <= '0;
    end else begin
      rd_valid <= issue && !issue_wr;
      if (issue && !issue_wr) begin
        rd_idx     <= issue_idx;
        src_bank_q <= issue_bank;
      end
    end
  end

  assign rd_data = bank_rdata[src_bank_q];

  // R6: a read issue returns its tag on the following cycle
  p_rd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !issue_wr) |=> (rd_valid && rd_idx == $past(issue_idx)));

  // R7: write elements never produce a read strobe
  p_wr_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && issue_wr) |=> !rd_valid);

endmodule

// File: rtl/vec_interleave_mem.sv
module vec_interleave_mem #(
  parameter int BANKS    = 4,
  parameter int ROWS     = 16,
  parameter int DATA_W   = 16,
  parameter int RECOVERY = 3,
  parameter int MAX_LEN  = 64,
  localparam int ADDR_W  = $clog2(BANKS * ROWS),
  localparam int BANK_W  = $clog2(BANKS),
  localparam int ROW_W   = ADDR_W - BANK_W,
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int LEN_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              stall,
  output logic              issue,
  output logic [IDX_W-1:0]  issue_idx,
  output logic [BANK_W-1:0] issue_bank,
  output logic              done,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [BANKS-1:0]  bank_ready;
  logic [BANKS-1:0]  bank_acc;
  logic [DATA_W-1:0] bank_rdata [BANKS];
  logic              issue_wr;
  logic [ROW_W-1:0]  issue_row;

  vim_seq #(
    .BANKS (BANKS),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_base  (cmd_base),
    .cmd_len   (cmd_len),
    .bank_ready(bank_ready),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .issue     (issue),
    .issue_wr  (issue_wr),
    .stall     (stall),
    .issue_idx (issue_idx),
    .issue_bank(issue_bank),
    .issue_row (issue_row),
    .done      (done)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_acc[b] = issue && (issue_bank == BANK_W'(b));

    vim_bank #(
      .ROWS    (ROWS),
      .DATA_W  (DATA_W),
      .RECOVERY(RECOVERY)
    ) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (bank_acc[b]),
      .acc_wr (issue_wr),
      .acc_row(issue_row),
      .wdata  (wr_data),
      .ready  (bank_ready[b]),
      .rdata  (bank_rdata[b])
    );
  end

  vim_return #(
    .BANKS (BANKS),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) ret_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .issue_wr  (issue_wr),
    .issue_idx (issue_idx),
    .issue_bank(issue_bank),
    .bank_rdata(bank_rdata),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
  );

  // R2: at most one bank is touched per cycle
  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_acc));

  // R9: nothing issues while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!issue && !stall));

  // R11: the command port is closed for the whole transfer
  p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R4: stall and issue never coincide
  p_stall_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && issue));

endmodule

// File: tb/vec_interleave_mem_tb.sv
module vec_interleave_mem_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BANKS    = 4;
  localparam int ROWS     = 16;
  localparam int DATA_W   = 16;
  localparam int RECOVERY = 3;
  localparam int MAX_LEN  = 64;
  localparam int ADDR_W   = $clog2(BANKS * ROWS);
  localparam int BANK_W   = $clog2(BANKS);
  localparam int IDX_W    = $clog2(MAX_LEN);
  localparam int LEN_W    = IDX_W + 1;
  localparam int WORDS    = BANKS * ROWS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_write = 1'b0;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic              cmd_ready;
  logic [DATA_W-1:0] wr_data;
  logic              busy, stall, issue, done, rd_valid;
  logic [IDX_W-1:0]  issue_idx, rd_idx;
  logic [BANK_W-1:0] issue_bank;
  logic [DATA_W-1:0] rd_data;

  int wseed = 0;
  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model [WORDS];

  function automatic logic [DATA_W-1:0] pat(input int seed, input int idx);
    return DATA_W'(seed * 4099 + idx * 97 + 3);
  endfunction

  assign wr_data = pat(wseed, int'(issue_idx));

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_interleave_mem #(
    .BANKS(BANKS), .ROWS(ROWS), .DATA_W(DATA_W),
    .RECOVERY(RECOVERY), .MAX_LEN(MAX_LEN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_base(cmd_base),
    .cmd_len(cmd_len), .cmd_ready(cmd_ready), .wr_data(wr_data),
    .busy(busy), .stall(stall), .issue(issue), .issue_idx(issue_idx),
    .issue_bank(issue_bank), .done(done), .rd_valid(rd_valid),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // caller stands at a falling edge; returns at the falling edge of the done cycle
  task automatic xfer(input bit wr, input int base, input int len, input bit intrude,
                      output int cyc, output int nstall);
    int exp_idx = 0;
    bit pend = 0;
    int p_idx = 0;
    int p_addr = 0;
    int guard = 0;
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_base  = ADDR_W'(base);
    cmd_len   = LEN_W'(len);
    @(negedge clk);
    cmd_valid = intrude;
    if (intrude) begin
      cmd_write = 1'b1;
      cmd_base  = ADDR_W'(40);
      cmd_len   = LEN_W'(4);
    end
    cyc = 0;
    nstall = 0;
    while (exp_idx < len && guard < 1000) begin
      guard++;
      cyc++;
      if (pend) begin
        chk(rd_valid == 1'b1, "R6", "rd_valid", int'(rd_valid), 1);
        chk(int'(rd_idx) == p_idx, "R6", "rd_idx", int'(rd_idx), p_idx);
        chk(rd_data == model[p_addr], "R6", "rd_data", int'(rd_data), int'(model[p_addr]));
        pend = 0;
      end else if (wr) begin
        chk(rd_valid == 1'b0, "R7", "rd_valid on write", int'(rd_valid), 0);
      end
      if (issue) begin
        int addr = (base + exp_idx) % WORDS;
        chk(int'(issue_idx) == exp_idx, "R5", "issue_idx", int'(issue_idx), exp_idx);
        chk(int'(issue_bank) == addr % BANKS, "R2", "issue_bank", int'(issue_bank), addr % BANKS);
        if (wr) model[addr] = wr_data;
        else begin
          pend = 1; p_idx = exp_idx; p_addr = addr;
        end
        exp_idx++;
      end else begin
        nstall++;
        chk(stall == 1'b1 && busy == 1'b1, "R4", "stall while waiting", int'(stall), 1);
        chk(int'(issue_idx) == exp_idx, "R4", "held index", int'(issue_idx), exp_idx);
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(exp_idx == len, "R5", "elements issued", exp_idx, len);
    if (pend) begin
      chk(rd_valid == 1'b1 && int'(rd_idx) == p_idx, "R6", "last rd tag", int'(rd_idx), p_idx);
      chk(rd_data == model[p_addr], "R6", "last rd_data", int'(rd_data), int'(model[p_addr]));
    end else if (wr) begin
      chk(rd_valid == 1'b0, "R7", "rd_valid after write", int'(rd_valid), 0);
    end
    chk(done == 1'b1, "R10", "done pulse", int'(done), 1);
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R10", "ready with done", int'(cmd_ready), 1);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
    chk(busy == 1'b0 && issue == 1'b0 && stall == 1'b0, "R1", "busy/issue/stall", int'(busy), 0);
    chk(done == 1'b0 && rd_valid == 1'b0, "R1", "done/rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_full_stream();
    int cyc, ns;
    wseed = 1;
    xfer(1'b1, 0, 64, 1'b0, cyc, ns);
    chk(cyc == 64, "R8", "write cycles", cyc, 64);
    chk(ns == 0, "R8", "write stalls", ns, 0);
    idle(1);
    chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
    idle(6);
    xfer(1'b0, 0, 64, 1'b0, cyc, ns);
    chk(cyc == 64, "R8", "read cycles", cyc, 64);
    chk(ns == 0, "R8", "read stalls", ns, 0);
    idle(6);
  endtask

  task automatic t_wrap();
    int cyc, ns;
    wseed = 3;
    xfer(1'b1, 60, 8, 1'b0, cyc, ns);
    idle(6);
    xfer(1'b0, 58, 12, 1'b0, cyc, ns);
    chk(ns == 0, "R2", "wrap read stalls", ns, 0);
    idle(6);
  endtask

  task automatic t_same_bank();
    int cyc, ns;
    xfer(1'b0, 5, 1, 1'b0, cyc, ns);
    xfer(1'b0, 5, 1, 1'b0, cyc, ns);
    chk(ns == RECOVERY - 1, "R3", "same address restart stalls", ns, RECOVERY - 1);
    chk(cyc == RECOVERY, "R3", "same address restart cycles", cyc, RECOVERY);
    xfer(1'b0, 9, 1, 1'b0, cyc, ns);
    chk(ns == RECOVERY - 1, "R3", "same bank other row stalls", ns, RECOVERY - 1);
    xfer(1'b0, 6, 1, 1'b0, cyc, ns);
    chk(ns == 0, "R3", "other bank no stall", ns, 0);
    idle(6);
    wseed = 7;
    xfer(1'b1, 17, 1, 1'b0, cyc, ns);
    xfer(1'b1, 21, 1, 1'b0, cyc, ns);
    chk(ns == RECOVERY - 1, "R3", "write same bank stalls", ns, RECOVERY - 1);
    idle(6);
    xfer(1'b0, 17, 5, 1'b0, cyc, ns);
    idle(6);
  endtask

  task automatic t_zero_len();
    cmd_valid = 1'b1;
    cmd_write = 1'b1;
    cmd_base  = ADDR_W'(3);
    cmd_len   = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(busy == 1'b0 && issue == 1'b0, "R9", "no transfer for len 0", int'(busy), 0);
      chk(done == 1'b0 && cmd_ready == 1'b1, "R9", "no done for len 0", int'(done), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_busy_ignore();
    int cyc, ns;
    wseed = 5;
    xfer(1'b1, 20, 8, 1'b1, cyc, ns);
    idle(6);
    xfer(1'b0, 40, 4, 1'b0, cyc, ns);
    chk(cyc == 4, "R11", "probe read cycles", cyc, 4);
    idle(6);
    xfer(1'b0, 20, 8, 1'b0, cyc, ns);
    idle(4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_full_stream();
    t_wrap();
    t_same_bank();
    t_zero_len();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule